// File: doc/BRIEF.md
# Universal Four-Stage Shift Register with Releasable Output Bus

This block holds a word of `WIDTH` bits (four by default) in a chain of stages. Stage 0 is the entry stage, and the last stage feeds a dedicated serial output. On each falling clock edge, one of two things happens. The register either captures a parallel word or moves every bit one stage along the chain. In the second case, a new bit from the serial input enters stage 0. An active-low clear empties the register at once, without waiting for a clock edge.

The stage contents reach the parallel bus through a per-bit three-state driver, which an active-low output enable controls. The serial tail output is taken before that driver and is never released. The register can therefore keep passing data along a chain, or around a feedback loop, while the parallel bus is handed to another driver. If the tail output is wired back to the serial input, the register rotates its contents.

Top module: `uniload_shreg`

## Requirements
- R1: When `shift_load` is 1, a falling edge of `clk` copies `par_in[i]` into stage i for every i. Stage 0 is the entry stage and stage `WIDTH-1` is the tail.
- R2: When `shift_load` is 0, a falling edge moves each stage i (for i ≥ 1) to take the old value of stage i-1, and stage 0 takes `serial_in`.
- R3: While `clear_n` is 0, all stages read 0 and `ser_out` reads 0. This takes effect without a clock edge and overrides any load or shift.
- R4: `ser_out` always equals the tail stage, whether or not the bus is enabled.
- R5: With `oe_n` at 0, `q[i]` shows stage i. With `oe_n` at 1, every bit of `q` is high impedance.
- R6: Stages keep loading and shifting while `oe_n` is 1. Once `oe_n` returns to 0, `q` shows the contents built up while it was released, with no clock edge needed.
- R7: A rising edge of `clk` leaves the stages unchanged, even when the inputs select a load of a different word.
- R8: With `ser_out` fed back to `serial_in`, each shift rotates the word by one stage toward the tail. For example, stages 0..3 = 0,1,0,1 become 1,0,1,0 and then 0,1,0,1 again.
- R9: After `WIDTH` consecutive shifts, stage i holds the serial bit applied i shifts before the last one. Four shifted 1s fill the register with ones, and the serial bits 0,1,0,1 leave stages 0..3 = 1,0,1,0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; stages update on its falling edge |
| clear_n | input | 1 | Asynchronous clear, active low |
| shift_load | input | 1 | 1 selects a parallel load, 0 selects a shift |
| oe_n | input | 1 | Bus output enable, active low |
| serial_in | input | 1 | Bit entering stage 0 on a shift |
| par_in | input | WIDTH | Parallel word; bit i loads stage i |
| q | output | WIDTH | Three-state stage outputs; bit i is stage i |
| ser_out | output | 1 | Tail stage, always driven |

## Verification
The assertions assume three things about the inputs. `shift_load`, `serial_in` and `par_in` hold known values at each falling edge. `clear_n` changes well away from that edge. The width is at least two stages. The stimulus meets these assumptions by driving all inputs one nanosecond after the rising edge, so every input is stable for more than a nanosecond before the active falling edge. When clear is asserted or the enable is toggled between falling edges, the bench drives the load control and `par_in` back to the current word. Any idle falling edge then reloads the same contents.

// File: rtl/shreg_pkg.sv
`timescale 1ns/100ps
package shreg_pkg;

    typedef enum logic {
        OP_SHIFT = 1'b0,
        OP_LOAD  = 1'b1
    } op_e;

    typedef struct packed {
        op_e  op;
        logic ser;
    } ctrl_t;

    function automatic op_e decode_op(input logic sel);
        return sel ? OP_LOAD : OP_SHIFT;
    endfunction

endpackage

// File: rtl/shreg_ctrl.sv
`timescale 1ns/100ps
module shreg_ctrl
    import shreg_pkg::*;
(
    input  logic  shift_load,
    input  logic  serial_in,
    output ctrl_t ctrl
);

    always_comb begin
        ctrl.op  = decode_op(shift_load);
        ctrl.ser = serial_in;
    end

endmodule

// File: rtl/shreg_stages.sv
`timescale 1ns/100ps
module shreg_stages
    import shreg_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clear_n,
    input  ctrl_t            ctrl,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] stage_q
);

    localparam int LAST = WIDTH - 1;

    logic [WIDTH-1:0] shift_src;

    // Stage 0 takes the serial bit; every later stage takes its predecessor.
    assign shift_src[0] = ctrl.ser;
    for (genvar i = 1; i < WIDTH; i++) begin : g_chain
        assign shift_src[i] = stage_q[i-1];
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        always_ff @(negedge clk or negedge clear_n) begin
            if (!clear_n)
                stage_q[i] <= 1'b0;
            else if (ctrl.op == OP_LOAD)
                stage_q[i] <= par_in[i];
            else
                stage_q[i] <= shift_src[i];
        end
    end

    // R1: a load edge captures the parallel word
    p_load_r1: assert property (@(negedge clk) disable iff (!clear_n)
        (ctrl.op == OP_LOAD) |=> (stage_q == $past(par_in)));

    // R2: a shift edge moves every stage one place and admits the serial bit
    p_shift_r2: assert property (@(negedge clk) disable iff (!clear_n)
        (ctrl.op == OP_SHIFT) |=>
            (stage_q == {$past(stage_q[LAST-1:0]), $past(ctrl.ser)}));

    // R3: clear holds every stage at zero
    p_clear_r3: assert property (@(negedge clk)
        (!clear_n) |-> (stage_q == '0));

endmodule

// File: rtl/shreg_outdrv.sv
`timescale 1ns/100ps
module shreg_outdrv #(
    parameter int WIDTH = 4
) (
    input  logic             oe_n,
    input  logic [WIDTH-1:0] stage_q,
    output logic [WIDTH-1:0] q,
    output logic             ser_out
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_drv
        assign q[i] = oe_n ? 1'bz : stage_q[i];
    end

    // The tail tap is taken ahead of the bus drivers and is never released.
    assign ser_out = stage_q[WIDTH-1];

endmodule

// File: rtl/uniload_shreg.sv
`timescale 1ns/100ps
module uniload_shreg
    import shreg_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clear_n,
    input  logic             shift_load,
    input  logic             oe_n,
    input  logic             serial_in,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] q,
    output logic             ser_out
);

    localparam int LAST = WIDTH - 1;

    ctrl_t            ctrl;
    logic [WIDTH-1:0] stage_q;

    shreg_ctrl u_ctrl (
        .shift_load (shift_load),
        .serial_in  (serial_in),
        .ctrl       (ctrl)
    );

    shreg_stages #(.WIDTH(WIDTH)) u_stages (
        .clk     (clk),
        .clear_n (clear_n),
        .ctrl    (ctrl),
        .par_in  (par_in),
        .stage_q (stage_q)
    );

    shreg_outdrv #(.WIDTH(WIDTH)) u_outdrv (
        .oe_n    (oe_n),
        .stage_q (stage_q),
        .q       (q),
        .ser_out (ser_out)
    );

    // R4: the tail output follows a loaded top bit, enabled or not
    p_tail_load_r4: assert property (@(negedge clk) disable iff (!clear_n)
        shift_load |=> (ser_out == $past(par_in[LAST])));

    // R4: after a shift the tail output shows the old next-to-last stage
    p_tail_shift_r4: assert property (@(negedge clk) disable iff (!clear_n)
        (!shift_load) |=> (ser_out == $past(stage_q[LAST-1])));

endmodule

// File: tb/uniload_shreg_tb_top.sv
`timescale 1ns/100ps
module uniload_shreg_tb_top;

    localparam int W = 4;

    typedef struct {
        logic [W-1:0] q_exp;
        logic         ser_exp;
        string        tag;
    } exp_t;

    logic         clk;
    logic         clear_n;
    logic         shift_load;
    logic         oe_n;
    logic         serial_in;
    logic [W-1:0] par_in;
    wire  [W-1:0] q_bus;
    wire          ser_out;

    logic [W-1:0] model;
    exp_t         sb_q[$];
    int           n_checks;
    int           n_fail;

    uniload_shreg #(.WIDTH(W)) dut_i (
        .clk        (clk),
        .clear_n    (clear_n),
        .shift_load (shift_load),
        .oe_n       (oe_n),
        .serial_in  (serial_in),
        .par_in     (par_in),
        .q          (q_bus),
        .ser_out    (ser_out)
    );

    initial clk = 1'b1;
    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Monitor: pops one expected item after each falling edge that has one queued.
    always @(negedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            chk(q_bus === e.q_exp, e.tag, q_bus, e.q_exp);
            chk(ser_out === e.ser_exp, {e.tag, " tail"}, {{(W-1){1'b0}}, ser_out},
                {{(W-1){1'b0}}, e.ser_exp});
        end
    end

    // Driver: applies one edge's inputs and queues the expected result.
    task automatic step(input logic sl, input logic si, input logic [W-1:0] pi,
                        input logic oe, input bit rot, input string tag);
        exp_t e;
        @(posedge clk); #1;
        shift_load = sl;
        par_in     = pi;
        oe_n       = oe;
        serial_in  = rot ? model[W-1] : si;
        if (sl) model = pi;
        else    model = {model[W-2:0], serial_in};
        e.q_exp   = oe ? {W{1'bz}} : model;
        e.ser_exp = model[W-1];
        e.tag     = tag;
        sb_q.push_back(e);
    endtask

    task automatic hold();
        shift_load = 1'b1;
        par_in     = model;
    endtask

    task automatic drain();
        wait (sb_q.size() == 0);
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        n_checks   = 0;
        n_fail     = 0;
        model      = '0;
        clear_n    = 1'b0;
        oe_n       = 1'b0;
        serial_in  = 1'b0;
        shift_load = 1'b1;
        par_in     = 4'b1111;
        repeat (2) @(posedge clk);
        #1;
        chk(q_bus === 4'b0000, "R3 reset state", q_bus, 4'b0000);
        chk(ser_out === 1'b0, "R3 reset tail", {3'b0, ser_out}, 4'b0000);
        hold();
        clear_n = 1'b1;

        // R9 / R2: serial 0,1,0,1 leaves stages 0..3 = 1,0,1,0
        step(1'b0, 1'b0, '0, 1'b0, 1'b0, "R2 shift 0");
        step(1'b0, 1'b1, '0, 1'b0, 1'b0, "R2 shift 1");
        step(1'b0, 1'b0, '0, 1'b0, 1'b0, "R2 shift 0");
        step(1'b0, 1'b1, '0, 1'b0, 1'b0, "R9 shift 1 gives 0101");
        drain();
        chk(q_bus === 4'b0101, "R9 pattern", q_bus, 4'b0101);

        // R1: loads (stage i = par_in[i])
        step(1'b1, 1'b0, 4'b1010, 1'b0, 1'b0, "R1 load A..D=0101");
        step(1'b1, 1'b1, 4'b0101, 1'b0, 1'b0, "R1 load A..D=1010");
        step(1'b1, 1'b0, 4'b1010, 1'b0, 1'b0, "R1 load A..D=0101 again");
        step(1'b1, 1'b0, 4'b0101, 1'b0, 1'b0, "R1 load A..D=1010");
        // R2: one shift after a load
        step(1'b0, 1'b1, 4'b0000, 1'b0, 1'b0, "R2 shift after load");
        step(1'b0, 1'b0, 4'b1111, 1'b0, 1'b0, "R2 shift ignores par_in");

        // R9: four ones fill the register
        for (int k = 0; k < W; k++)
            step(1'b0, 1'b1, '0, 1'b0, 1'b0, "R9 fill ones");
        drain();
        chk(q_bus === 4'b1111, "R9 all ones", q_bus, 4'b1111);

        // R5 / R6 / R4: activity while the bus is released
        step(1'b1, 1'b0, 4'b1010, 1'b1, 1'b0, "R5 load while released");
        step(1'b0, 1'b0, '0, 1'b1, 1'b0, "R6 shift while released");
        step(1'b0, 1'b1, '0, 1'b1, 1'b0, "R4 tail while released");
        drain();
        @(posedge clk); #1;
        hold();
        oe_n = 1'b0;
        #0.5;
        chk(q_bus === model, "R6 re-enable shows hidden state", q_bus, model);
        step(1'b0, 1'b0, '0, 1'b1, 1'b0, "R5 release again");
        drain();
        @(posedge clk); #1;
        hold();
        oe_n = 1'b0;
        #0.5;
        chk(q_bus === model, "R6 second re-enable", q_bus, model);

        // R8: rotation through the tail feedback
        step(1'b1, 1'b0, 4'b1010, 1'b0, 1'b0, "R8 load A..D=0101");
        step(1'b0, 1'b0, '0, 1'b0, 1'b1, "R8 rotate to 1010");
        step(1'b0, 1'b0, '0, 1'b0, 1'b1, "R8 rotate to 0101");
        drain();
        chk(q_bus === 4'b1010, "R8 rotation returns", q_bus, 4'b1010);

        // R7: a rising edge with a different load word changes nothing
        step(1'b1, 1'b0, 4'b0110, 1'b0, 1'b0, "R1 load 0110");
        drain();
        #0.5;
        par_in     = 4'b1001;
        shift_load = 1'b1;
        @(posedge clk); #0.5;
        chk(q_bus === 4'b0110, "R7 rising edge ignored", q_bus, 4'b0110);
        #0.5;
        hold();

        // R3: clear without an edge, and over a pending load
        step(1'b1, 1'b0, 4'b1111, 1'b0, 1'b0, "R1 load ones");
        drain();
        @(posedge clk); #1;
        par_in     = 4'b1111;
        shift_load = 1'b1;
        clear_n    = 1'b0;
        #0.5;
        chk(q_bus === 4'b0000, "R3 clear with clock high", q_bus, 4'b0000);
        chk(ser_out === 1'b0, "R3 clear tail", {3'b0, ser_out}, 4'b0000);
        model = '0;
        @(negedge clk); #1;
        chk(q_bus === 4'b0000, "R3 clear beats load", q_bus, 4'b0000);
        @(posedge clk); #1;
        hold();
        clear_n = 1'b1;
        step(1'b0, 1'b1, '0, 1'b0, 1'b0, "R2 shift after clear");
        drain();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule